// File: doc/BRIEF.md
# Parallel Flash Erase Sequencer

This controller sits on the host side of a group of byte-wide, bulk-erasable flash devices that share one address and write-data bus, and erases all of them together. Each device has its own active-low chip enable and its own read-data lane. A run starts with a preprogram pass. Every byte address is read from all devices at once. When a device returns a non-zero byte, a request is raised to an external program sequencer, with a mask of the devices that still need that byte cleared. The same address is then read again.

Once the whole array reads zero, the controller repeats erase rounds. In each round, every device that is neither passed nor failed is sent the two-write erase command, and the controller then waits out the erase time. It then visits the devices one at a time. For each device it issues the erase-verify command at that device's own resume address, waits the settle time, and reads the byte back. A device that reads FFh on its last byte is marked passed, is sent the read command on its own, and is left out of every later erase write. The first byte that does not read FFh ends that device's turn and becomes its resume address for the next round.

The run ends when every device has passed, or when the round limit is reached. At the limit, every device that has not passed is marked failed. At the end the read command goes to all devices, the programming supply request drops, and the per-device pass flags stay valid until the next start. With one device, this is the single-device erase flow.

Top module: `pe_erase_seq`

## Requirements
- R1: Out of reset, and whenever no run is in progress, all chip enables are high (1 = deselected). The write strobe, read strobe, program request, busy and programming-supply request are all low.
- R2: Before any erase command, every byte address is read from all devices with all chip enables low. A non-zero byte raises `pgm_req` at that address, with `pgm_mask` bit d set for each device d whose byte was non-zero. The address is read again after `pgm_done`. No erase command is issued while any device still holds a non-zero byte.
- R3: An erase round writes 20h twice, with the chip enable low only for devices that are neither passed nor failed. At least ERASE_WAIT cycles then pass before any erase-verify write.
- R4: Verification writes A0h at the device's resume address with only that device's chip enable low. At least VERIFY_WAIT cycles later, it reads that device. The byte passes only if it reads FFh.
- R5: Each device keeps its own resume address, starting at 0. Later rounds restart verification at the first byte that failed. A device that passes after k rounds therefore receives exactly DEPTH + k − 1 verify reads.
- R6: A device that passes its last byte is sent 00h with only its own chip enable low, and receives no further 20h writes. A device that needs k ≤ MAX_PULSE rounds receives exactly k erase rounds.
- R7: The round count starts at 1 and never exceeds MAX_PULSE. After round MAX_PULSE, every device that has not passed is marked failed, with its `dev_pass` bit = 0.
- R8: A run ends with one write of 00h to all devices, with all chip enables low. Then `finished` = 1 and `vpp_hi` = 0, and `dev_pass` holds 1 for each device that passed.
- R9: Each erase-verify write (A0h) selects exactly one device.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| pgm_done | input | 1 | One-cycle completion pulse from the program sequencer |
| rd_data | input | 8*N_DEV | Read byte from each device, device d in bits 8d+7..8d |
| busy | output | 1 | A run is in progress |
| finished | output | 1 | Last run is complete; held until the next start |
| vpp_hi | output | 1 | Request for the programming supply |
| dev_ce_n | output | N_DEV | Active-low chip enable per device |
| wr_en | output | 1 | Write strobe on the shared bus |
| rd_en | output | 1 | Read strobe |
| bus_addr | output | ADDR_W | Shared byte address |
| wr_data | output | 8 | Shared write data (command byte) |
| pgm_req | output | 1 | Preprogram request for `bus_addr` |
| pgm_mask | output | N_DEV | Devices to program to 00h |
| dev_pass | output | N_DEV | Per-device erase pass flag |

## Verification
A behavioural model of each device returns FFh for a byte once that device has received enough erase rounds. Bytes below a per-device split point erase one round earlier than bytes above it. This tells a controller that resumes at the failing byte apart from one that restarts at zero, because the verify-read counts differ. Random rounds-needed values and random preload contents per device show whether masking follows each device's own progress, rather than the slowest or the fastest device. A directed case with all-zero contents checks that no program request is raised. A case with devices needing 1001 and 1200 rounds shows whether the limit stops erasing at exactly 1000 rounds and fails only those devices. For the 1001-round device, a partial pass at the last round is also reflected in its read count.

// File: rtl/pe_pkg.sv
package pe_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_PRE_RD, S_PRE_PGM, S_ERA1, S_ERA2, S_ERA_WAIT, S_PICK,
    S_VER_CMD, S_VER_WAIT, S_VER_RD, S_MASK, S_STEP, S_ROUND, S_FINISH
  } seq_state_t;

  localparam logic [7:0] CMD_READ    = 8'h00;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_EVERIFY = 8'hA0;
  localparam logic [7:0] BYTE_CLEAR  = 8'hFF;
  localparam logic [7:0] BYTE_ZERO   = 8'h00;
endpackage

// File: rtl/pe_wait_timer.sv
module pe_wait_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? limit : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/pe_dev_track.sv
module pe_dev_track #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          adv,
  input  logic          set_pass,
  input  logic          set_fail,
  output logic [AW-1:0] resume,
  output logic          passed,
  output logic          failed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resume <= '0;
      passed <= 1'b0;
      failed <= 1'b0;
    end else if (clear) begin
      resume <= '0;
      passed <= 1'b0;
      failed <= 1'b0;
    end else begin
      if (adv)      resume <= resume + 1'b1;
      if (set_pass) passed <= 1'b1;
      if (set_fail) failed <= 1'b1;
    end
  end
endmodule

// File: rtl/pe_erase_seq.sv
module pe_erase_seq
  import pe_pkg::*;
#(
  parameter int N_DEV       = 4,
  parameter int ADDR_W      = 17,
  parameter int MAX_PULSE   = 1000,
  parameter int ERASE_WAIT  = 500000,
  parameter int VERIFY_WAIT = 300
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 pgm_done,
  input  logic [8*N_DEV-1:0]   rd_data,
  output logic                 busy,
  output logic                 finished,
  output logic                 vpp_hi,
  output logic [N_DEV-1:0]     dev_ce_n,
  output logic                 wr_en,
  output logic                 rd_en,
  output logic [ADDR_W-1:0]    bus_addr,
  output logic [7:0]           wr_data,
  output logic                 pgm_req,
  output logic [N_DEV-1:0]     pgm_mask,
  output logic [N_DEV-1:0]     dev_pass
);
  localparam int DW    = (N_DEV > 1) ? $clog2(N_DEV) : 1;
  localparam int PW    = $clog2(MAX_PULSE + 1);
  localparam int WMAX  = (ERASE_WAIT > VERIFY_WAIT) ? ERASE_WAIT : VERIFY_WAIT;
  localparam int TW    = $clog2(WMAX + 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  seq_state_t         st_q, st_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [DW-1:0]      cur_q, cur_d;
  logic [PW-1:0]      pulse_q, pulse_d;
  logic [N_DEV-1:0]   mask_q, mask_d;
  logic               fin_q, fin_d;
  logic               addr_en, cur_en, pulse_en, mask_en;

  logic [N_DEV-1:0]   passed, failed, active, cur_sel, nz;
  logic [N_DEV-1:0]   adv, set_pass, set_fail;
  logic               clr;
  logic [ADDR_W-1:0]  resume [N_DEV];
  logic [7:0]         rbyte  [N_DEV];
  logic               tmr_load, tmr_done;
  logic [TW-1:0]      tmr_limit;

  for (genvar d = 0; d < N_DEV; d++) begin : g_dev
    assign rbyte[d]   = rd_data[8*d +: 8];
    assign nz[d]      = (rbyte[d] != BYTE_ZERO);
    assign cur_sel[d] = (cur_q == DW'(d));
    pe_dev_track #(.AW(ADDR_W)) u_trk (
      .clk(clk), .rst_n(rst_n_s), .clear(clr), .adv(adv[d]),
      .set_pass(set_pass[d]), .set_fail(set_fail[d]),
      .resume(resume[d]), .passed(passed[d]), .failed(failed[d])
    );
  end

  assign active = ~(passed | failed);

  pe_wait_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n_s), .load(tmr_load), .limit(tmr_limit),
    .expired(tmr_done)
  );

  always_comb begin
    st_d = st_q;   addr_d = addr_q;  cur_d = cur_q;  pulse_d = pulse_q;
    mask_d = mask_q; fin_d = fin_q;
    addr_en = 1'b0; cur_en = 1'b0; pulse_en = 1'b0; mask_en = 1'b0;
    dev_ce_n = '1;  wr_en = 1'b0;  rd_en = 1'b0;  wr_data = CMD_READ;
    bus_addr = addr_q; pgm_req = 1'b0;
    clr = 1'b0; adv = '0; set_pass = '0; set_fail = '0;
    tmr_load = 1'b0; tmr_limit = TW'(ERASE_WAIT);
    unique case (st_q)
      S_IDLE: if (start) begin
        st_d = S_PRE_RD; clr = 1'b1; fin_d = 1'b0;
        addr_d = '0; addr_en = 1'b1;
      end
      S_PRE_RD: begin
        dev_ce_n = '0; rd_en = 1'b1;
        if (|nz) begin
          mask_d = nz; mask_en = 1'b1; st_d = S_PRE_PGM;
        end else if (addr_q == LAST_ADDR) begin
          pulse_d = PW'(1); pulse_en = 1'b1; st_d = S_ERA1;
        end else begin
          addr_d = addr_q + 1'b1; addr_en = 1'b1;
        end
      end
      S_PRE_PGM: begin
        pgm_req = 1'b1;
        if (pgm_done) st_d = S_PRE_RD;
      end
      S_ERA1: begin
        wr_en = 1'b1; wr_data = CMD_ERASE; dev_ce_n = ~active; st_d = S_ERA2;
      end
      S_ERA2: begin
        wr_en = 1'b1; wr_data = CMD_ERASE; dev_ce_n = ~active;
        tmr_load = 1'b1; st_d = S_ERA_WAIT;
      end
      S_ERA_WAIT: if (tmr_done) begin
        cur_d = '0; cur_en = 1'b1; st_d = S_PICK;
      end
      S_PICK: st_d = (|(active & cur_sel)) ? S_VER_CMD : S_STEP;
      S_VER_CMD: begin
        wr_en = 1'b1; wr_data = CMD_EVERIFY; dev_ce_n = ~cur_sel;
        bus_addr = resume[cur_q];
        tmr_load = 1'b1; tmr_limit = TW'(VERIFY_WAIT); st_d = S_VER_WAIT;
      end
      S_VER_WAIT: begin
        bus_addr = resume[cur_q];
        if (tmr_done) st_d = S_VER_RD;
      end
      S_VER_RD: begin
        rd_en = 1'b1; dev_ce_n = ~cur_sel; bus_addr = resume[cur_q];
        if (rbyte[cur_q] == BYTE_CLEAR) begin
          if (resume[cur_q] == LAST_ADDR) begin
            set_pass = cur_sel; st_d = S_MASK;
          end else begin
            adv = cur_sel; st_d = S_VER_CMD;
          end
        end else begin
          st_d = S_STEP;
        end
      end
      S_MASK: begin
        wr_en = 1'b1; wr_data = CMD_READ; dev_ce_n = ~cur_sel; st_d = S_STEP;
      end
      S_STEP: begin
        if (cur_q == DW'(N_DEV - 1)) st_d = S_ROUND;
        else begin
          cur_d = cur_q + 1'b1; cur_en = 1'b1; st_d = S_PICK;
        end
      end
      S_ROUND: begin
        if (active == '0) st_d = S_FINISH;
        else if (pulse_q == PW'(MAX_PULSE)) begin
          set_fail = active; st_d = S_FINISH;
        end else begin
          pulse_d = pulse_q + 1'b1; pulse_en = 1'b1; st_d = S_ERA1;
        end
      end
      S_FINISH: begin
        wr_en = 1'b1; wr_data = CMD_READ; dev_ce_n = '0;
        fin_d = 1'b1; st_d = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q    <= S_IDLE;
      addr_q  <= '0;
      cur_q   <= '0;
      pulse_q <= '0;
      mask_q  <= '0;
      fin_q   <= 1'b0;
    end else begin
      st_q  <= st_d;
      fin_q <= fin_d;
      if (addr_en)  addr_q  <= addr_d;
      if (cur_en)   cur_q   <= cur_d;
      if (pulse_en) pulse_q <= pulse_d;
      if (mask_en)  mask_q  <= mask_d;
    end
  end

  assign busy     = (st_q != S_IDLE);
  assign vpp_hi   = busy;
  assign finished = fin_q;
  assign pgm_mask = mask_q;
  assign dev_pass = passed;
endmodule

// File: rtl/pe_erase_seq_chk.sv
module pe_erase_seq_chk #(
  parameter int N_DEV       = 4,
  parameter int ADDR_W      = 17,
  parameter int MAX_PULSE   = 1000,
  parameter int ERASE_WAIT  = 500000,
  parameter int VERIFY_WAIT = 300
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               busy,
  input logic               finished,
  input logic               vpp_hi,
  input logic [N_DEV-1:0]   dev_ce_n,
  input logic               wr_en,
  input logic               rd_en,
  input logic [7:0]         wr_data,
  input logic               pgm_req,
  input logic [N_DEV-1:0]   pgm_mask,
  input logic [N_DEV-1:0]   dev_pass
);
  logic [31:0] since_era, since_ver, era_writes;
  logic        ver_seen;
  logic        era_wr, ver_wr, run_go;

  assign era_wr = wr_en && (wr_data == 8'h20);
  assign ver_wr = wr_en && (wr_data == 8'hA0);
  assign run_go = start && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_era  <= '0;
      since_ver  <= '0;
      era_writes <= '0;
      ver_seen   <= 1'b0;
    end else begin
      if (era_wr)                  since_era <= '0;
      else if (since_era != '1)    since_era <= since_era + 1'b1;
      if (ver_wr)                  since_ver <= '0;
      else if (since_ver != '1)    since_ver <= since_ver + 1'b1;
      if (run_go)                  era_writes <= '0;
      else if (era_wr)             era_writes <= era_writes + 1'b1;
      if (run_go)                  ver_seen <= 1'b0;
      else if (ver_wr)             ver_seen <= 1'b1;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (&dev_ce_n) && !wr_en && !rd_en && !pgm_req && !vpp_hi);

  assert_pgm_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_req |-> (pgm_mask != '0) && (&dev_ce_n));

  assert_erase_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ver_wr |-> since_era >= 32'(ERASE_WAIT));

  assert_verify_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && ver_seen) |-> since_ver >= 32'(VERIFY_WAIT));

  assert_no_erase_passed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    era_wr |-> ((~dev_ce_n) & dev_pass) == '0);

  assert_round_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    era_writes <= 32'(2 * MAX_PULSE));

  assert_done_supply_R8: assert property (@(posedge clk) disable iff (!rst_n)
    finished |-> !busy && !vpp_hi);

  assert_one_verify_dev_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ver_wr |-> $countones(~dev_ce_n) == 1);
endmodule

bind pe_erase_seq pe_erase_seq_chk #(
  .N_DEV(N_DEV), .ADDR_W(ADDR_W), .MAX_PULSE(MAX_PULSE),
  .ERASE_WAIT(ERASE_WAIT), .VERIFY_WAIT(VERIFY_WAIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .finished(finished),
  .vpp_hi(vpp_hi), .dev_ce_n(dev_ce_n), .wr_en(wr_en), .rd_en(rd_en),
  .wr_data(wr_data), .pgm_req(pgm_req), .pgm_mask(pgm_mask), .dev_pass(dev_pass)
);

// File: tb/pe_erase_seq_bench.sv
module pe_erase_seq_bench;
  localparam int N      = 3;
  localparam int AW     = 4;
  localparam int DEPTH  = 1 << AW;
  localparam int MAXP   = 1000;
  localparam int EWAIT  = 6;
  localparam int VWAIT  = 2;
  localparam int WD_LIMIT = 190000;

  logic clk = 1'b0;
  logic rst_n;
  logic start, pgm_done;
  logic [8*N-1:0] rd_data;
  logic busy, finished, vpp_hi, wr_en, rd_en, pgm_req;
  logic [N-1:0] dev_ce_n, pgm_mask, dev_pass;
  logic [AW-1:0] bus_addr;
  logic [7:0] wr_data;

  always #10 clk = ~clk;

  pe_erase_seq #(.N_DEV(N), .ADDR_W(AW), .MAX_PULSE(MAXP),
                 .ERASE_WAIT(EWAIT), .VERIFY_WAIT(VWAIT)) u_pe_erase_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .pgm_done(pgm_done),
    .rd_data(rd_data), .busy(busy), .finished(finished), .vpp_hi(vpp_hi),
    .dev_ce_n(dev_ce_n), .wr_en(wr_en), .rd_en(rd_en), .bus_addr(bus_addr),
    .wr_data(wr_data), .pgm_req(pgm_req), .pgm_mask(pgm_mask), .dev_pass(dev_pass)
  );

  // stimulus-side settings (written only by the bench tasks)
  logic [7:0] init_mem [N][DEPTH];
  int need [N];
  int split [N];

  // device model state (written only by the model process)
  logic [7:0] mem [N][DEPTH];
  int pulses [N], reads [N];
  logic [7:0] last_cmd [N];
  logic setup [N], vmode [N], bad [N];
  int pgm_cnt, pcnt, cyc, era_t, ver_t, min_egap, min_vgap;

  function automatic logic dev_nonzero(int d);
    for (int a = 0; a < DEPTH; a++) if (mem[d][a] != 8'h00) return 1'b1;
    return 1'b0;
  endfunction

  always_comb begin
    for (int d = 0; d < N; d++) begin
      int lim;
      lim = need[d] - ((int'(bus_addr) < split[d]) ? 1 : 0);
      rd_data[8*d +: 8] = vmode[d] ? ((pulses[d] >= lim) ? 8'hFF : 8'h00)
                                   : mem[d][bus_addr];
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (start && !busy) begin
      for (int d = 0; d < N; d++) begin
        for (int a = 0; a < DEPTH; a++) mem[d][a] <= init_mem[d][a];
        pulses[d] <= 0; reads[d] <= 0; last_cmd[d] <= 8'hEE;
        setup[d] <= 1'b0; vmode[d] <= 1'b0; bad[d] <= 1'b0;
      end
      pgm_cnt <= 0; pcnt <= 0; pgm_done <= 1'b0;
      min_egap <= 1 << 30; min_vgap <= 1 << 30;
    end else begin
      if (wr_en) begin
        if (wr_data == 8'h20) era_t <= cyc;
        if (wr_data == 8'hA0) begin
          ver_t <= cyc;
          if (cyc - era_t < min_egap) min_egap <= cyc - era_t;
        end
        for (int d = 0; d < N; d++) if (!dev_ce_n[d]) begin
          last_cmd[d] <= wr_data;
          if (wr_data == 8'h20) begin
            vmode[d] <= 1'b0;
            if (setup[d]) begin
              pulses[d] <= pulses[d] + 1; setup[d] <= 1'b0;
              if (dev_nonzero(d)) bad[d] <= 1'b1;
            end else setup[d] <= 1'b1;
          end else begin
            setup[d] <= 1'b0;
            vmode[d] <= (wr_data == 8'hA0);
          end
        end
      end
      if (rd_en) for (int d = 0; d < N; d++) if (!dev_ce_n[d] && vmode[d]) begin
        reads[d] <= reads[d] + 1;
        if (cyc - ver_t < min_vgap) min_vgap <= cyc - ver_t;
      end
      if (pgm_req && !pgm_done) begin
        if (pcnt == 1) begin
          for (int d = 0; d < N; d++) if (pgm_mask[d]) mem[d][bus_addr] <= 8'h00;
          pgm_done <= 1'b1; pgm_cnt <= pgm_cnt + 1; pcnt <= 0;
        end else pcnt <= pcnt + 1;
      end else pgm_done <= 1'b0;
    end
  end

  int checks = 0, errors = 0, ncyc = 0;
  logic wd_hit = 1'b0;

  always @(posedge clk) begin
    ncyc <= ncyc + 1;
    if (ncyc == WD_LIMIT) wd_hit <= 1'b1;
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_pulses(int k);
    return (k > MAXP) ? MAXP : k;
  endfunction

  function automatic int exp_reads(int k, int s);
    if (k <= MAXP) return DEPTH + k - 1;
    if (k == MAXP + 1) return MAXP + s;
    return MAXP;
  endfunction

  task automatic run_case(input string tag);
    int exp_pgm;
    exp_pgm = 0;
    for (int a = 0; a < DEPTH; a++) begin
      logic any;
      any = 1'b0;
      for (int d = 0; d < N; d++) if (init_mem[d][a] != 8'h00) any = 1'b1;
      if (any) exp_pgm++;
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    while (!finished && !wd_hit) @(negedge clk);
    if (wd_hit) return;
    $display("case %s done", tag);
    check(pgm_cnt == exp_pgm, "R2 preprogram requests", pgm_cnt, exp_pgm);
    check(min_egap >= EWAIT, "R3 erase wait", min_egap, EWAIT);
    check(min_vgap >= VWAIT, "R4 verify wait", min_vgap, VWAIT);
    check(!vpp_hi && !busy, "R8 supply low after run", int'(vpp_hi), 0);
    for (int d = 0; d < N; d++) begin
      check(bad[d] == 1'b0, "R2 erase before zero", int'(bad[d]), 0);
      check(pulses[d] == exp_pulses(need[d]), "R6/R7 erase rounds",
            pulses[d], exp_pulses(need[d]));
      check(reads[d] == exp_reads(need[d], split[d]), "R5 verify reads",
            reads[d], exp_reads(need[d], split[d]));
      check(dev_pass[d] == (need[d] <= MAXP), "R7 pass flag",
            int'(dev_pass[d]), int'(need[d] <= MAXP));
      check(last_cmd[d] == 8'h00, "R8 final read command",
            int'(last_cmd[d]), 0);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; start = 1'b0; cyc = 0; era_t = 0; ver_t = 0;
    pgm_done = 1'b0;
    for (int d = 0; d < N; d++) begin
      need[d] = 1; split[d] = 0; vmode[d] = 1'b0; pulses[d] = 0;
      for (int a = 0; a < DEPTH; a++) begin
        init_mem[d][a] = 8'h00; mem[d][a] = 8'h00;
      end
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    check(dev_ce_n == '1, "R1 chip enables after reset", int'(dev_ce_n), 7);
    check(!vpp_hi && !wr_en && !rd_en && !pgm_req, "R1 quiet bus after reset",
          int'({vpp_hi, wr_en, rd_en, pgm_req}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && finished == 1'b0, "R1 idle after release",
          int'({busy, finished}), 0);

    // directed: already zero, single round each (no preprogram)
    run_case("zero-one-round");

    // random mixtures
    for (int r = 0; r < 4 && !wd_hit; r++) begin
      for (int d = 0; d < N; d++) begin
        need[d] = 1 + int'($urandom_range(5));
        split[d] = int'($urandom_range(DEPTH - 1));
        for (int a = 0; a < DEPTH; a++)
          init_mem[d][a] = ($urandom_range(1) == 0) ? 8'h00 : 8'($urandom_range(255));
      end
      run_case("random");
    end

    // directed: round limit with partial progress on one device
    if (!wd_hit) begin
      need[0] = 2;    split[0] = 3;
      need[1] = 1200; split[1] = 0;
      need[2] = MAXP + 1; split[2] = 5;
      for (int d = 0; d < N; d++)
        for (int a = 0; a < DEPTH; a++) init_mem[d][a] = (a == 7) ? 8'h5A : 8'h00;
      run_case("limit");
    end

    if (wd_hit) check(1'b0, "watchdog", ncyc, WD_LIMIT);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule